// File: doc/BRIEF.md
# Switching-Matrix Host Command Front End

This block sits between a microprocessor bus and the control logic of a time-slot switching matrix. The host writes opcodes and operand bytes over a shared bus. A command/data select line marks each write as one or the other. Both chip selects must be low for a write or a read to count. Write-side values are captured on the rising edge of the write strobe. That strobe is then brought into the system clock through a synchronizer. Once an opcode has received all of its operands, the block issues a one-cycle execute strobe with the opcode and operands to the downstream matrix control. The strobe is launched on a falling clock edge.

Each device compares two address pins against two select pins. When the device is not addressed, the command is not simply dropped. Connect-type commands become disconnects, the global query still runs, and the rest are cancelled after their operands have been consumed. Reads return one of two result registers, and the bus is driven only when the device is addressed. An active-low ready line signals two things. It stays low while an invalid opcode is outstanding. It also drops for two cycles when the matrix reports an active channel or a finished extraction.

Top module: `swm_host_if`

## Requirements
- R1: While `rst_n` is low, `bus_oe` is 0, `exe_stb` is 0 and `rdy_n` is 1, whatever the bus pins do.
- R2: A write or read is valid only when `cs_a_n` and `cs_b_n` are both 0. A write made with either select high has no effect on `exe_stb` or `rdy_n`.
- R3: A write with `cmd_sel`=1 is an opcode and a write with `cmd_sel`=0 is an operand. Opcodes 1, 2 and 3 take two operands: the first goes to `exe_arg0` and the second to `exe_arg1`. Opcode 4 takes one operand into `exe_arg0`. Opcodes 5 and 6 take none. `exe_stb` fires only once the last operand is in. Operands with no pending opcode are ignored.
- R4: Only `bus_in[4:0]` is taken on a write. The opcode is that 5-bit value, unsigned.
- R5: The device is addressed when `adr_a`==`sel_a` and `adr_b`==`sel_b`. For a command, the match is captured together with its opcode write.
- R6: When a command is not addressed, opcodes 1 and 3 are issued as `exe_op`=0 (disconnect) with their operands, and opcode 5 is issued unchanged. Opcodes 2, 4 and 6 issue no strobe, but their operands are still consumed.
- R7: `bus_oe` is 1 only while both selects are low, `rd_n` is low, the device is addressed and reset is released. `bus_out` then shows result register 1 when `cmd_sel`=0 and result register 2 when `cmd_sel`=1.
- R8: An opcode outside 1..6 drives `rdy_n` low. It stays low through operand writes and other cycles until a valid opcode is written.
- R9: A one-cycle `chan_hit` or `xtr_done` drives `rdy_n` low for exactly 2 clock cycles. `xtr_done` loads result register 2 from `res_data`, and `or1_ld` loads result register 1.
- R10: `exe_stb` rises only on a falling clock edge and is high for exactly one clock period per issued command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| wr_n | input | 1 | Write strobe, captured on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| cmd_sel | input | 1 | Command/data select (write) or register select (read) |
| adr_a | input | 1 | Address pin, pair A |
| sel_a | input | 1 | Select pin, pair A |
| adr_b | input | 1 | Address pin, pair B |
| sel_b | input | 1 | Select pin, pair B |
| bus_in | input | 8 | Host bus, write direction |
| bus_out | output | 8 | Host bus, read direction |
| bus_oe | output | 1 | Bus drive enable |
| exe_stb | output | 1 | Execute strobe to matrix control |
| exe_op | output | 3 | Issued operation (0 = disconnect) |
| exe_arg0 | output | 5 | First operand |
| exe_arg1 | output | 5 | Second operand |
| res_data | input | 8 | Result value from matrix control |
| or1_ld | input | 1 | Load result register 1 |
| xtr_done | input | 1 | Extraction finished; load result register 2 |
| chan_hit | input | 1 | Query found an active channel |
| rdy_n | output | 1 | Ready/alert, active low |

## Verification
A wrong operand count or a lost pending opcode shows at the ports as a missing, early or extra `exe_stb`. It becomes visible within about four clocks of the last write strobe. A wrong match capture or a wrong rewrite shows as the wrong `exe_op` on the next issued command, or as a strobe where none is expected. A stuck alert or a wrong pulse counter changes `rdy_n` on the first clock after the trigger. A bad result register shows on the next read of that register.

// File: rtl/swm_host_if.sv
module swm_host_if #(
  parameter int DW    = 8,
  parameter int IW    = 5,
  parameter int PULSE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          cmd_sel,
  input  logic          adr_a,
  input  logic          sel_a,
  input  logic          adr_b,
  input  logic          sel_b,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          exe_stb,
  output logic [2:0]    exe_op,
  output logic [IW-1:0] exe_arg0,
  output logic [IW-1:0] exe_arg1,
  input  logic [DW-1:0] res_data,
  input  logic          or1_ld,
  input  logic          xtr_done,
  input  logic          chan_hit,
  output logic          rdy_n
);
  localparam int PCW = $clog2(PULSE + 1);

  logic          match;
  logic [IW-1:0] w_val;
  logic          w_cmd, w_ok, w_match;
  logic [2:0]    ws;
  logic          wr_evt;
  logic [IW-1:0] op_q, a0;
  logic          m_q, busy, go, bad;
  logic [1:0]    got;
  logic [DW-1:0] or1, or2;
  logic [PCW-1:0] pcnt;
  logic [IW-1:0] d_op;
  logic          d_m, op_ok;
  logic [3:0]    rt;
  logic [2:0]    p_op;
  logic [IW-1:0] p_a0, p_a1;
  logic          unused_hi;

  function automatic logic [1:0] need_of(input logic [IW-1:0] op);
    if (op == IW'(1) || op == IW'(2) || op == IW'(3)) return 2'd2;
    if (op == IW'(4)) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [3:0] route(input logic [IW-1:0] op, input logic m);
    if (m) return {1'b1, op[2:0]};
    if (op == IW'(1) || op == IW'(3)) return {1'b1, 3'd0};
    if (op == IW'(5)) return {1'b1, op[2:0]};
    return {1'b0, op[2:0]};
  endfunction

  assign match     = (adr_a == sel_a) && (adr_b == sel_b);
  assign unused_hi = ^bus_in[DW-1:IW];

  always_ff @(posedge wr_n or negedge rst_n) begin
    if (!rst_n) begin
      w_val   <= '0;
      w_cmd   <= 1'b0;
      w_ok    <= 1'b0;
      w_match <= 1'b0;
    end else begin
      w_val   <= bus_in[IW-1:0];
      w_cmd   <= cmd_sel;
      w_ok    <= ~cs_a_n & ~cs_b_n;
      w_match <= match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws <= 3'b111;
    else        ws <= {ws[1:0], wr_n};
  end

  assign wr_evt = ws[1] & ~ws[2] & w_ok;
  assign op_ok  = (w_val != '0) && (w_val <= IW'(6));
  assign d_op   = w_cmd ? w_val : op_q;
  assign d_m    = w_cmd ? w_match : m_q;
  assign rt     = route(d_op, d_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; a0 <= '0; m_q <= 1'b0; busy <= 1'b0; got <= '0;
      go <= 1'b0; bad <= 1'b0;
      p_op <= '0; p_a0 <= '0; p_a1 <= '0;
      or1 <= '0; or2 <= '0; pcnt <= '0;
    end else begin
      go <= 1'b0;
      if (wr_evt) begin
        if (w_cmd) begin
          bad  <= ~op_ok;
          busy <= 1'b0;
          got  <= '0;
          if (op_ok) begin
            op_q <= w_val;
            m_q  <= w_match;
            if (need_of(w_val) == 2'd0) begin
              go   <= rt[3];
              p_op <= rt[2:0];
              p_a0 <= '0;
              p_a1 <= '0;
            end else begin
              busy <= 1'b1;
            end
          end
        end else if (busy) begin
          got <= got + 2'd1;
          a0  <= w_val;
          if (got + 2'd1 == need_of(op_q)) begin
            busy <= 1'b0;
            go   <= rt[3];
            p_op <= rt[2:0];
            p_a0 <= (got == 2'd0) ? w_val : a0;
            p_a1 <= (got == 2'd0) ? '0 : w_val;
          end
        end
      end
      if (or1_ld)   or1 <= res_data;
      if (xtr_done) or2 <= res_data;
      if (chan_hit | xtr_done) pcnt <= PCW'(PULSE);
      else if (pcnt != '0)     pcnt <= pcnt - 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) exe_stb <= 1'b0;
    else        exe_stb <= go;
  end

  assign exe_op   = p_op;
  assign exe_arg0 = p_a0;
  assign exe_arg1 = p_a1;
  assign rdy_n    = ~(bad | (pcnt != '0));
  assign bus_oe   = rst_n & ~cs_a_n & ~cs_b_n & ~rd_n & match;
  assign bus_out  = cmd_sel ? or2 : or1;
endmodule

module swm_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adr_a,
  input logic       sel_a,
  input logic       adr_b,
  input logic       sel_b,
  input logic       bus_oe,
  input logic       exe_stb,
  input logic [2:0] exe_op,
  input logic       chan_hit,
  input logic       rdy_n
);
  always_comb begin
    if (rst_n === 1'b0) begin
      AST_RESET_QUIET: assert (!bus_oe); // R1
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exe_stb |=> !exe_stb); // R10

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    exe_stb |-> (exe_op != 3'd7)); // R6

  AST_HIT_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    chan_hit |=> !rdy_n); // R9

  AST_OE_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (adr_a == sel_a && adr_b == sel_b)); // R7
endmodule

bind swm_host_if swm_host_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .adr_a(adr_a), .sel_a(sel_a), .adr_b(adr_b),
  .sel_b(sel_b), .bus_oe(bus_oe), .exe_stb(exe_stb), .exe_op(exe_op),
  .chan_hit(chan_hit), .rdy_n(rdy_n)
);

// File: tb/swm_host_if_tb.sv
module swm_host_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cmd_sel = 1'b0;
  logic adr_a = 1'b0, sel_a = 1'b0, adr_b = 1'b0, sel_b = 1'b0;
  logic [7:0] bus_in = '0, res_data = '0;
  logic or1_ld = 1'b0, xtr_done = 1'b0, chan_hit = 1'b0;
  logic [7:0] bus_out;
  logic bus_oe, exe_stb, rdy_n;
  logic [2:0] exe_op;
  logic [4:0] exe_arg0, exe_arg1;

  int checks = 0, fails = 0, cyc = 0, stb_cnt = 0, bad_edge = 0;
  logic [2:0] l_op;
  logic [4:0] l_a0, l_a1;
  bit done = 0;

  always #10 clk = ~clk;

  swm_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
    .rd_n(rd_n), .cmd_sel(cmd_sel), .adr_a(adr_a), .sel_a(sel_a), .adr_b(adr_b),
    .sel_b(sel_b), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .exe_stb(exe_stb), .exe_op(exe_op), .exe_arg0(exe_arg0), .exe_arg1(exe_arg1),
    .res_data(res_data), .or1_ld(or1_ld), .xtr_done(xtr_done),
    .chan_hit(chan_hit), .rdy_n(rdy_n)
  );

  always @(posedge clk) begin
    if (exe_stb) begin
      stb_cnt++;
      l_op = exe_op; l_a0 = exe_arg0; l_a1 = exe_arg1;
    end
  end

  always @(posedge exe_stb) if (clk !== 1'b0) bad_edge++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: act=%0d exp<=50000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cs(input logic a_n, input logic b_n, input logic c, input logic [7:0] v);
    @(negedge clk);
    cs_a_n = a_n; cs_b_n = b_n; cmd_sel = c; bus_in = v; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_a_n = 1'b1; cs_b_n = 1'b1;
  endtask

  task automatic wr(input logic c, input logic [7:0] v);
    wr_cs(1'b0, 1'b0, c, v);
  endtask

  task automatic t_reset;
    @(negedge clk);
    cs_a_n = 0; cs_b_n = 0; rd_n = 0;
    #1;
    check("R1 oe in reset", bus_oe, 0);
    check("R1 stb in reset", exe_stb, 0);
    check("R1 rdy in reset", rdy_n, 1);
    rd_n = 1; cs_a_n = 1; cs_b_n = 1;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_two_operands;
    int s0 = stb_cnt;
    wr(1, 8'd1);
    wr(0, 8'd5);
    check("R3 no strobe before last operand", stb_cnt - s0, 0);
    wr(0, 8'd9);
    check("R3 strobe after two operands", stb_cnt - s0, 1);
    check("R3 op", l_op, 1);
    check("R3 arg0", l_a0, 5);
    check("R3 arg1", l_a1, 9);
    s0 = stb_cnt;
    wr(0, 8'd3);
    check("R3 orphan operand ignored", stb_cnt - s0, 0);
  endtask

  task automatic t_one_and_zero;
    int s0 = stb_cnt;
    wr(1, 8'd4);
    wr(0, 8'hFF);
    check("R3 op4 one operand", stb_cnt - s0, 1);
    check("R4 low five bits", l_a0, 31);
    check("R3 op4 code", l_op, 4);
    wr(1, 8'hE5);
    check("R4 opcode upper bits dropped", stb_cnt - s0, 2);
    check("R3 op5 immediate", l_op, 5);
  endtask

  task automatic t_chip_select;
    int s0 = stb_cnt;
    wr_cs(1'b0, 1'b1, 1'b1, 8'd5);
    check("R2 cs_b high blocks write", stb_cnt - s0, 0);
    wr_cs(1'b1, 1'b0, 1'b1, 8'd0);
    check("R2 invalid op with cs_a high no alert", rdy_n, 1);
  endtask

  task automatic t_mismatch;
    int s0;
    sel_a = 1; adr_a = 0;
    s0 = stb_cnt;
    wr(1, 8'd1); wr(0, 8'd7); wr(0, 8'd8);
    check("R6 op1 becomes disconnect", l_op, 0);
    check("R6 op1 strobe", stb_cnt - s0, 1);
    check("R6 disconnect arg1", l_a1, 8);
    adr_a = 1; sel_a = 1; adr_b = 1; sel_b = 0;
    wr(1, 8'd3); wr(0, 8'd2); wr(0, 8'd4);
    check("R5 pair B mismatch rewrites op3", l_op, 0);
    wr(1, 8'd5);
    check("R6 op5 runs unchanged", l_op, 5);
    s0 = stb_cnt;
    wr(1, 8'd2); wr(0, 8'd1); wr(0, 8'd1);
    wr(1, 8'd6);
    wr(1, 8'd4);
    adr_b = 0; sel_b = 0;
    wr(0, 8'd6);
    check("R6 ops 2,4,6 cancelled, operands consumed", stb_cnt - s0, 0);
    wr(1, 8'd4); wr(0, 8'd11);
    check("R5 match restored op4", l_op, 4);
    check("R5 match restored strobe", stb_cnt - s0, 1);
    adr_a = 0; sel_a = 0;
  endtask

  task automatic t_invalid;
    wr(1, 8'd0);
    check("R8 opcode 0 alert", rdy_n, 0);
    wr(0, 8'd3);
    repeat (5) @(negedge clk);
    check("R8 alert sticky", rdy_n, 0);
    wr(1, 8'd5);
    check("R8 cleared by valid op", rdy_n, 1);
    wr(1, 8'd7);
    check("R8 opcode 7 alert", rdy_n, 0);
    wr(1, 8'd20);
    check("R8 opcode 20 alert", rdy_n, 0);
    wr(1, 8'd6);
    check("R8 cleared by op6", rdy_n, 1);
  endtask

  task automatic t_pulse;
    @(negedge clk); chan_hit = 1;
    @(negedge clk); chan_hit = 0;
    check("R9 hit cycle1 low", rdy_n, 0);
    @(negedge clk);
    check("R9 hit cycle2 low", rdy_n, 0);
    @(negedge clk);
    check("R9 hit released", rdy_n, 1);
    @(negedge clk); xtr_done = 1; res_data = 8'hA5;
    @(negedge clk); xtr_done = 0; res_data = 8'h00;
    check("R9 extract cycle1 low", rdy_n, 0);
    @(negedge clk);
    check("R9 extract cycle2 low", rdy_n, 0);
    @(negedge clk);
    check("R9 extract released", rdy_n, 1);
  endtask

  task automatic t_read;
    @(negedge clk); or1_ld = 1; res_data = 8'h3C;
    @(negedge clk); or1_ld = 0; res_data = 8'h00;
    cs_a_n = 0; cs_b_n = 0; cmd_sel = 0; rd_n = 0;
    #1;
    check("R7 oe on read", bus_oe, 1);
    check("R7 reg1 value", bus_out, 8'h3C);
    cmd_sel = 1; #1;
    check("R9 reg2 loaded by extract", bus_out, 8'hA5);
    sel_b = 1; #1;
    check("R7 no drive on mismatch", bus_oe, 0);
    sel_b = 0; rd_n = 1; #1;
    check("R7 no drive with rd high", bus_oe, 0);
    cs_b_n = 1; rd_n = 0; #1;
    check("R2 no drive with cs_b high", bus_oe, 0);
    rd_n = 1; cs_a_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_two_operands();
    t_one_and_zero();
    t_chip_select();
    t_mismatch();
    t_invalid();
    t_pulse();
    t_read();
    check("R10 strobe rises on falling edge", bad_edge, 0);
    check("R10 strobe total", stb_cnt, 9);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule